// File: doc/BRIEF.md
# Accumulator Arithmetic/Logic Unit with Packed Flags

This block is the data-path core of a small 8-bit accumulator machine. Each cycle in which `op_valid` is high, it captures the accumulator value, a second operand, the current flag byte and an operation code. The operand goes into an internal temporary register. One clock later the block presents the new accumulator value, the new flag byte and a write strobe for the accumulator. The surrounding sequencer feeds `flags_out` back as `flags_in` on later operations.

The operations are add and subtract, each with or without a carry or borrow; increment and decrement; AND, OR and XOR; one's complement; and four single-bit rotates. Two of the rotates wrap around the carry and two go through it. The flag byte keeps five meaningful bits at fixed positions. Some operations leave some flags untouched, and those flags come from `flags_in`. The incoming carry is bit 0 of `flags_in`.

Top module: `acc_alu`

## Requirements
- R1: Inputs are registered on the rising clock edge when `op_valid` is 1. `res_we`, `res_out` and `flags_out` reflect that operation from the edge onward until the next edge. When no operation was captured at the last edge, `res_we` is 0 and `res_out` and `flags_out` are 0. An active-low reset gives the same zero state.
- R2: Op codes 0 (add) and 1 (add with carry) give `acc + opnd (+ flags_in[0])` modulo 256. CY is the carry out of bit 7. AC is the carry out of bit 3 into bit 4.
- R3: Op codes 2 (subtract) and 3 (subtract with borrow) give `acc - opnd (- flags_in[0])` modulo 256. CY is set when the unsigned acc is less than opnd plus the borrow-in. AC is set when the low nibble of acc is less than the low nibble of opnd plus the borrow-in.
- R4: Op codes 4 (increment) and 5 (decrement) give acc plus or minus 1 and ignore opnd. S, Z, P and AC are updated; for AC, a low-nibble carry sets it on increment and a low-nibble borrow sets it on decrement. CY is copied from `flags_in[0]`.
- R5: Op codes 6 (AND), 7 (OR) and 8 (XOR) combine acc and opnd bitwise. They clear CY and AC and update S, Z and P.
- R6: Op code 9 gives the one's complement of acc. Every meaningful flag is copied unchanged from `flags_in`.
- R7: Op code 10 rotates left and op code 11 rotates right, in both cases around the register. The bit that leaves one end enters at the other end and is also copied into CY.
- R8: Op code 12 rotates left through carry and op code 13 rotates right through carry. The old CY enters the vacated bit, and the bit shifted out becomes the new CY.
- R9: The four rotates change only CY; S, Z, AC and P are copied from `flags_in`.
- R10: Flag byte layout: S at bit 7 (result MSB), Z at bit 6 (result all zero), AC at bit 4, P at bit 2 (1 for an even count of ones in the result), CY at bit 0. Bits 5, 3 and 1 of `flags_out` are always 0.
- R11: Op codes 14 and 15 are undefined. When one is captured, `res_we` is 0 and `res_out` and `flags_out` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| op_valid | input | 1 | Capture an operation this edge |
| op_code | input | 4 | Operation select (see requirements) |
| acc_in | input | 8 | Accumulator value |
| opnd_in | input | 8 | Second operand, held in the temporary register |
| flags_in | input | 8 | Current flag byte; bit 0 is the incoming carry |
| res_out | output | 8 | Value to write back to the accumulator |
| flags_out | output | 8 | New flag byte |
| res_we | output | 1 | Accumulator write strobe |

## Verification
The properties assume that `flags_in` and `op_code` are known whenever `op_valid` is high. They compare `flags_out` against the flag byte that was captured with the operation, not against the live input. The stimulus therefore changes inputs only on the falling clock edge and keeps them stable through the following rising edge. Every vector supplies an explicit flag byte, including bytes with the unused bits set, so the copy-through checks operate on defined values.

// File: rtl/acc_alu_pkg.sv
package acc_alu_pkg;

  typedef enum logic [3:0] {
    OP_ADD  = 4'd0,
    OP_ADC  = 4'd1,
    OP_SUB  = 4'd2,
    OP_SBB  = 4'd3,
    OP_INC  = 4'd4,
    OP_DEC  = 4'd5,
    OP_AND  = 4'd6,
    OP_OR   = 4'd7,
    OP_XOR  = 4'd8,
    OP_CPL  = 4'd9,
    OP_ROLW = 4'd10,
    OP_RORW = 4'd11,
    OP_ROLC = 4'd12,
    OP_RORC = 4'd13,
    OP_RSV0 = 4'd14,
    OP_RSV1 = 4'd15
  } alu_op_e;

  localparam int FLAG_W  = 8;
  localparam int FB_SIGN = 7;
  localparam int FB_ZERO = 6;
  localparam int FB_HALF = 4;
  localparam int FB_PAR  = 2;
  localparam int FB_CY   = 0;
  localparam logic [FLAG_W-1:0] FLAG_LIVE =
    (8'd1 << FB_SIGN) | (8'd1 << FB_ZERO) | (8'd1 << FB_HALF) |
    (8'd1 << FB_PAR)  | (8'd1 << FB_CY);

  function automatic logic is_arith(alu_op_e o);
    return o inside {OP_ADD, OP_ADC, OP_SUB, OP_SBB, OP_INC, OP_DEC};
  endfunction

  function automatic logic is_logic(alu_op_e o);
    return o inside {OP_AND, OP_OR, OP_XOR, OP_CPL};
  endfunction

  function automatic logic is_rotate(alu_op_e o);
    return o inside {OP_ROLW, OP_RORW, OP_ROLC, OP_RORC};
  endfunction

endpackage

// File: rtl/alu_arith.sv
module alu_arith
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e        op,
  input  logic [W-1:0]   a,
  input  logic [W-1:0]   b,
  input  logic           cin,
  output logic [W-1:0]   res,
  output logic           cy,
  output logic           ac
);
  localparam int HALF = W / 2;

  function automatic logic [W:0] add_w(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{W{1'b0}}, c};
  endfunction

  function automatic logic [W:0] sub_w(logic [W-1:0] x, logic [W-1:0] y, logic c);
    return {1'b0, x} - {1'b0, y} - {{W{1'b0}}, c};
  endfunction

  function automatic logic [HALF:0] add_h(logic [HALF-1:0] x, logic [HALF-1:0] y, logic c);
    return {1'b0, x} + {1'b0, y} + {{HALF{1'b0}}, c};
  endfunction

  function automatic logic [HALF:0] sub_h(logic [HALF-1:0] x, logic [HALF-1:0] y, logic c);
    return {1'b0, x} - {1'b0, y} - {{HALF{1'b0}}, c};
  endfunction

  logic [W-1:0] rhs;
  logic         c_eff;
  logic         do_sub;
  logic [W:0]   full;
  logic [HALF:0] low;

  always_comb begin
    rhs    = b;
    c_eff  = 1'b0;
    do_sub = 1'b0;
    unique case (op)
      OP_ADC:  c_eff = cin;
      OP_SUB:  do_sub = 1'b1;
      OP_SBB:  begin do_sub = 1'b1; c_eff = cin; end
      OP_INC:  rhs = {{(W-1){1'b0}}, 1'b1};
      OP_DEC:  begin rhs = {{(W-1){1'b0}}, 1'b1}; do_sub = 1'b1; end
      default: ;
    endcase
    full = do_sub ? sub_w(a, rhs, c_eff) : add_w(a, rhs, c_eff);
    low  = do_sub ? sub_h(a[HALF-1:0], rhs[HALF-1:0], c_eff)
                  : add_h(a[HALF-1:0], rhs[HALF-1:0], c_eff);
    res  = full[W-1:0];
    cy   = full[W];
    ac   = low[HALF];
  end
endmodule

// File: rtl/alu_logic.sv
module alu_logic
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  output logic [W-1:0] res
);
  always_comb begin
    unique case (op)
      OP_AND:  res = a & b;
      OP_OR:   res = a | b;
      OP_XOR:  res = a ^ b;
      default: res = ~a;
    endcase
  end
endmodule

// File: rtl/alu_rotate.sv
module alu_rotate
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  alu_op_e      op,
  input  logic [W-1:0] a,
  input  logic         cin,
  output logic [W-1:0] res,
  output logic         cy
);
  logic go_left;
  logic thru_cy;
  logic fill;

  always_comb begin
    go_left = (op == OP_ROLW) || (op == OP_ROLC);
    thru_cy = (op == OP_ROLC) || (op == OP_RORC);
    if (go_left) begin
      cy   = a[W-1];
      fill = thru_cy ? cin : a[W-1];
      res  = {a[W-2:0], fill};
    end else begin
      cy   = a[0];
      fill = thru_cy ? cin : a[0];
      res  = {fill, a[W-1:1]};
    end
  end
endmodule

// File: rtl/acc_alu.sv
module acc_alu
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              op_valid,
  input  logic [3:0]        op_code,
  input  logic [W-1:0]      acc_in,
  input  logic [W-1:0]      opnd_in,
  input  logic [FLAG_W-1:0] flags_in,
  output logic [W-1:0]      res_out,
  output logic [FLAG_W-1:0] flags_out,
  output logic              res_we
);
  function automatic logic even_ones(logic [W-1:0] v);
    return ~(^v);
  endfunction

  // capture stage: accumulator copy, temporary operand register, flags
  logic              st_valid;
  alu_op_e           st_op;
  logic [W-1:0]      st_acc;
  logic [W-1:0]      st_tmp;
  logic [FLAG_W-1:0] st_flags;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      st_valid <= 1'b0;
      st_op    <= OP_ADD;
      st_acc   <= '0;
      st_tmp   <= '0;
      st_flags <= '0;
    end else begin
      st_valid <= op_valid;
      if (op_valid) begin
        st_op    <= alu_op_e'(op_code);
        st_acc   <= acc_in;
        st_tmp   <= opnd_in;
        st_flags <= flags_in;
      end
    end
  end

  logic         cy_old;
  logic [W-1:0] ar_res, lg_res, rt_res;
  logic         ar_cy, ar_ac, rt_cy;

  assign cy_old = st_flags[FB_CY];

  alu_arith #(.W(W)) u_arith (
    .op(st_op), .a(st_acc), .b(st_tmp), .cin(cy_old),
    .res(ar_res), .cy(ar_cy), .ac(ar_ac)
  );

  alu_logic #(.W(W)) u_logic (
    .op(st_op), .a(st_acc), .b(st_tmp), .res(lg_res)
  );

  alu_rotate #(.W(W)) u_rot (
    .op(st_op), .a(st_acc), .cin(cy_old), .res(rt_res), .cy(rt_cy)
  );

  // named decode events
  logic op_legal, upd_szp, upd_ac, upd_cy;
  logic grp_ar, grp_lg, grp_rt, is_cpl, keeps_cy;
  logic [W-1:0] sel_res;
  logic         sel_cy, sel_ac;

  always_comb begin
    grp_ar   = is_arith(st_op);
    grp_lg   = is_logic(st_op);
    grp_rt   = is_rotate(st_op);
    is_cpl   = (st_op == OP_CPL);
    keeps_cy = (st_op == OP_INC) || (st_op == OP_DEC);
    op_legal = grp_ar || grp_lg || grp_rt;
    upd_szp  = grp_ar || (grp_lg && !is_cpl);
    upd_ac   = upd_szp;
    upd_cy   = (grp_ar && !keeps_cy) || (grp_lg && !is_cpl) || grp_rt;
    if (grp_ar) begin
      sel_res = ar_res; sel_cy = ar_cy; sel_ac = ar_ac;
    end else if (grp_rt) begin
      sel_res = rt_res; sel_cy = rt_cy; sel_ac = 1'b0;
    end else begin
      sel_res = lg_res; sel_cy = 1'b0;  sel_ac = 1'b0;
    end
  end

  always_comb begin
    res_we    = st_valid && op_legal;
    res_out   = '0;
    flags_out = '0;
    if (res_we) begin
      res_out   = sel_res;
      flags_out = st_flags & FLAG_LIVE;
      if (upd_szp) begin
        flags_out[FB_SIGN] = sel_res[W-1];
        flags_out[FB_ZERO] = (sel_res == '0);
        flags_out[FB_PAR]  = even_ones(sel_res);
      end
      if (upd_ac) flags_out[FB_HALF] = sel_ac;
      if (upd_cy) flags_out[FB_CY]   = sel_cy;
    end
  end
endmodule

// File: rtl/acc_alu_chk.sv
module acc_alu_chk
  import acc_alu_pkg::*;
#(
  parameter int W = 8
) (
  input logic              clk,
  input logic              rst_n,
  input logic              op_valid,
  input logic              st_valid,
  input alu_op_e           st_op,
  input logic [FLAG_W-1:0] st_flags,
  input logic [W-1:0]      res_out,
  input logic [FLAG_W-1:0] flags_out,
  input logic              res_we
);
  logic lg3, rot, stepper;
  assign lg3     = st_op inside {OP_AND, OP_OR, OP_XOR};
  assign rot     = st_op inside {OP_ROLW, OP_RORW, OP_ROLC, OP_RORC};
  assign stepper = (st_op == OP_INC) || (st_op == OP_DEC);

  AST_SPARE_BITS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
    (flags_out & 8'h2A) == 8'h00); // R10

  AST_IDLE_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(op_valid) |-> !res_we); // R1

  AST_RSVD_NO_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
    (st_valid && st_op inside {OP_RSV0, OP_RSV1}) |-> (!res_we && res_out == '0)); // R11

  AST_LOGIC_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && lg3) |-> (flags_out[FB_CY] == 1'b0 && flags_out[FB_HALF] == 1'b0)); // R5

  AST_CPL_KEEPS: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && st_op == OP_CPL) |-> flags_out == (st_flags & 8'hD5)); // R6

  AST_ROT_ONLY_CY: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && rot) |-> flags_out[7:1] == (st_flags[7:1] & 7'h6A)); // R9

  AST_STEP_KEEPS_CY: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && stepper) |-> flags_out[FB_CY] == st_flags[FB_CY]); // R4

  AST_ZERO_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && (lg3 || is_arith(st_op))) |-> flags_out[FB_ZERO] == (res_out == '0)); // R10

  AST_PARITY_MATCH: assert property (@(posedge clk) disable iff (!rst_n)
    (res_we && (lg3 || is_arith(st_op))) |->
      flags_out[FB_PAR] == ($countones(res_out) % 2 == 0)); // R10
endmodule

bind acc_alu acc_alu_chk #(.W(W)) u_chk (
  .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .st_valid(st_valid),
  .st_op(st_op), .st_flags(st_flags), .res_out(res_out),
  .flags_out(flags_out), .res_we(res_we)
);

// File: tb/test_acc_alu.sv
module test_acc_alu;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       op_valid = 1'b0;
  logic [3:0] op_code = 4'd0;
  logic [7:0] acc_in = 8'h00, opnd_in = 8'h00, flags_in = 8'h00;
  logic [7:0] res_out, flags_out;
  logic       res_we;

  int errors = 0;
  int checks = 0;

  always #2 clk = ~clk; // 250 MHz

  acc_alu i_acc_alu (
    .clk(clk), .rst_n(rst_n), .op_valid(op_valid), .op_code(op_code),
    .acc_in(acc_in), .opnd_in(opnd_in), .flags_in(flags_in),
    .res_out(res_out), .flags_out(flags_out), .res_we(res_we)
  );

  // {req, op, acc, opnd, flags_in, exp_res, exp_flags}; req A means R10
  localparam int NV = 18;
  localparam logic [47:0] VEC [NV] = '{
    48'h2_0_3A_46_00_80_90, // R2 half carry, sign
    48'h2_0_FF_01_00_00_55, // R2 carry out, zero
    48'h2_1_10_20_01_31_00, // R2 carry in used
    48'h3_2_05_07_00_FE_91, // R3 borrow, nibble borrow
    48'h3_3_50_10_01_3F_14, // R3 borrow in used
    48'h3_2_42_42_00_00_44, // R3 equal operands
    48'h4_4_FF_AA_01_00_55, // R4 wrap, CY kept 1, opnd ignored
    48'h4_5_00_33_00_FF_94, // R4 wrap down, CY kept 0
    48'h5_6_F0_3C_01_30_04, // R5 AND clears CY
    48'h5_7_00_00_11_00_44, // R5 OR clears AC
    48'h5_8_5A_FF_00_A5_84, // R5 XOR
    48'h6_9_5A_00_FF_A5_D5, // R6 complement, flags kept
    48'h7_A_81_00_00_03_01, // R7 left around
    48'h7_B_01_00_00_80_01, // R7 right around
    48'h8_C_80_00_00_00_01, // R8 left through, Z not touched
    48'h8_D_01_00_01_80_01, // R8 right through, old CY to MSB
    48'h9_C_41_00_C5_83_C4, // R9 other flags kept
    48'hA_B_02_00_94_01_94  // R9 R10 kept flags, CY cleared
  };

  task automatic check(input string req, input logic [15:0] got, input logic [15:0] exp);
    checks++;
    if (got !== exp) begin
      errors++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic issue(input logic v, input logic [3:0] op, input logic [7:0] a,
                       input logic [7:0] b, input logic [7:0] f);
    op_valid = v; op_code = op; acc_in = a; opnd_in = b; flags_in = f;
    @(negedge clk);
  endtask

  initial begin : watchdog
    repeat (2000) @(posedge clk);
    errors++; checks++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    check("R1", {7'd0, res_we, 8'h00}, 16'h0000);
    check("R1", {res_out, flags_out}, 16'h0000);
    rst_n = 1'b1;
    @(negedge clk);

    for (int i = 0; i < NV; i++) begin
      issue(1'b1, VEC[i][43:40], VEC[i][39:32], VEC[i][31:24], VEC[i][23:16]);
      check($sformatf("R%0d vec%0d", VEC[i][47:44], i), {res_out, flags_out}, VEC[i][15:0]);
      check($sformatf("R1 we vec%0d", i), {15'd0, res_we}, 16'h0001);
    end

    // R1 no capture: outputs return to zero, no write
    issue(1'b0, 4'd0, 8'h12, 8'h34, 8'h00);
    check("R1 idle", {res_out, flags_out}, 16'h0000);
    check("R1 idle we", {15'd0, res_we}, 16'h0000);

    // R11 reserved codes
    issue(1'b1, 4'd14, 8'h12, 8'h34, 8'hFF);
    check("R11 op14", {res_out, flags_out}, 16'h0000);
    check("R11 op14 we", {15'd0, res_we}, 16'h0000);
    issue(1'b1, 4'd15, 8'hFF, 8'hFF, 8'hFF);
    check("R11 op15", {7'd0, res_we, res_out}, 16'h0000);

    // R10 spare bits cleared even when set on input (XOR path)
    issue(1'b1, 4'd8, 8'h0F, 8'h0F, 8'h2A);
    check("R10 spare", {res_out, flags_out}, 16'h0044);

    // R2 largest carry-in sum
    issue(1'b1, 4'd1, 8'hFF, 8'hFF, 8'h01);
    check("R2 max", {res_out, flags_out}, 16'hFF95);

    // R1 reset in the middle clears the write strobe
    issue(1'b1, 4'd0, 8'h01, 8'h01, 8'h00);
    check("R2 small", {res_out, flags_out}, 16'h0200);
    rst_n = 1'b0;
    op_valid = 1'b0;
    @(negedge clk);
    check("R1 reset", {7'd0, res_we, res_out}, 16'h0000);

    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule